// File: doc/BRIEF.md
# Serial Boot Loader Handshake Sequencer

This block takes over a serial boot link once the receive bit rate has been locked. It marks the end of rate adjustment with a sync byte and then waits for a key byte from the host, which it acknowledges. After that it reads a 16-bit program length and then the program image. Every byte it takes in is sent straight back to the host, so the host can confirm the byte arrived intact. Image bytes go to an on-chip RAM through a single registered write port, at addresses that count up from zero.

Once the image is complete, the block looks at a flag that tells it whether the target memory already holds data. If it does, the block asks an external engine to erase all of it. A clean erase, or memory that was already blank, is reported with an acknowledge byte, and the block then raises a run output that hands control to the loaded program. A failed erase is reported with an error byte, and the block then locks into a halt state that ignores all further input until reset.

Input bytes are accepted only while the echo slot is empty. The transmitter therefore never loses a reply, and the host is throttled through `rx_ready`.

Top module: `boot_handshake`

## Requirements
- R1: While `rst` is high, the outputs `tx_valid`, `ram_we`, `erase_req`, `run`, `halted` and `rx_ready` are all low.
- R2: A one-cycle `start` pulse in the idle state causes exactly one byte, 0x00, to be transmitted before any other byte.
- R3: While waiting for the key byte, every received byte other than 0x55 is consumed with no transmission. 0x55 is answered by exactly one 0xAA.
- R4: After the key, two length bytes are taken: the upper byte first, then the lower byte. Each is echoed unchanged, in order.
- R5: For a length N, the next N received bytes are each echoed, and byte i (counting from 0) is written once to RAM address i. The block makes exactly N writes.
- R6: `tx_valid` is a one-cycle pulse that is issued only in a cycle where `tx_busy` was low at the preceding clock edge. While an echo is still waiting to be sent, `rx_ready` is low, so no two RAM writes occur in adjacent cycles.
- R7: A length of zero makes no RAM write and moves straight on to the memory check.
- R8: If `mem_has_data` is low at the check, `erase_req` never rises. One 0xAA is sent and `run` then goes high.
- R9: If `mem_has_data` is high at the check, `erase_req` rises and stays high until `erase_done` or `erase_fail`. `erase_done` is followed by one 0xAA and then `run`.
- R10: `erase_fail` causes one 0xFF to be sent, after which `halted` is high, `run` stays low, `rx_ready` stays low, and no byte is transmitted or written.
- R11: Once high, `run` and `halted` each stay high until reset, and the two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Bit-rate lock complete pulse |
| rx_valid | input | 1 | Received byte available |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Block takes the byte this cycle when `rx_valid` is high |
| tx_busy | input | 1 | Transmitter cannot take a byte |
| tx_valid | output | 1 | One-cycle transmit request |
| tx_data | output | 8 | Byte to transmit |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | ADDR_W | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| mem_has_data | input | 1 | Target memory is not blank |
| erase_req | output | 1 | Erase-all request, held until answered |
| erase_done | input | 1 | Erase finished cleanly |
| erase_fail | input | 1 | Erase could not complete |
| run | output | 1 | Start the loaded program |
| halted | output | 1 | Permanent halt after erase error |

## Verification
A wrong internal state shows up at the ports within one host byte. A byte-counter slip appears as a missing or extra echo, or as a RAM write to the wrong address in the cycle after that byte is accepted. A wrong branch after the image is complete shows in the next transmitted byte: 0xAA or 0xFF in the wrong place, or an erase request that should not be there. Because acceptance is throttled by the echo slot, a lost echo stalls the host at once rather than corrupting later bytes silently. The final run or halt level then confirms the outcome a few cycles later.

// File: rtl/bl_pkg.sv
package bl_pkg;
  localparam int LEN_W = 16;

  localparam logic [7:0] BYTE_SYNC = 8'h00;
  localparam logic [7:0] BYTE_KEY  = 8'h55;
  localparam logic [7:0] BYTE_ACK  = 8'hAA;
  localparam logic [7:0] BYTE_ERR  = 8'hFF;

  typedef enum logic [3:0] {
    S_IDLE,
    S_WAIT_KEY,
    S_LEN_HI,
    S_LEN_LO,
    S_DATA,
    S_CHECK,
    S_ERASE,
    S_DRAIN,
    S_RUN,
    S_HALT
  } bl_state_e;
endpackage

// File: rtl/bl_tx_slot.sv
module bl_tx_slot (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [7:0] load_byte,
  input  logic       tx_busy,
  output logic       pend,
  output logic       tx_valid,
  output logic [7:0] tx_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend     <= 1'b0;
      tx_valid <= 1'b0;
      tx_data  <= 8'h00;
    end else begin
      tx_valid <= 1'b0;
      if (pend && !tx_busy) begin
        tx_valid <= 1'b1;
        pend     <= 1'b0;
      end
      if (load) begin
        pend    <= 1'b1;
        tx_data <= load_byte;
      end
    end
  end

  // R6: the sequencer never overwrites a byte still waiting to go out
  a_r6_no_overwrite: assert property (@(posedge clk) disable iff (rst)
    load |-> !pend);
  // R6: a request follows a cycle where the transmitter was free
  a_r6_idle_tx: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> !$past(tx_busy));
  a_r6_pulse: assert property (@(posedge clk) disable iff (rst)
    tx_valid |=> !tx_valid);
endmodule

// File: rtl/bl_len_counter.sv
module bl_len_counter #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hi_we,
  input  logic             lo_we,
  input  logic [7:0]       byte_in,
  input  logic             clr,
  input  logic             step,
  output logic [LEN_W-1:0] len_q,
  output logic [LEN_W-1:0] cnt_q
);
  localparam int HI_W = LEN_W - 8;

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q <= '0;
      cnt_q <= '0;
    end else begin
      if (hi_we) len_q[LEN_W-1:8] <= byte_in[HI_W-1:0];
      if (lo_we) len_q[7:0] <= byte_in;
      if (clr) cnt_q <= '0;
      else if (step) cnt_q <= cnt_q + LEN_W'(1);
    end
  end
endmodule

// File: rtl/boot_handshake.sv
module boot_handshake
  import bl_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_ready,
  input  logic              tx_busy,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  input  logic              mem_has_data,
  output logic              erase_req,
  input  logic              erase_done,
  input  logic              erase_fail,
  output logic              run,
  output logic              halted
);
  bl_state_e state, state_d;
  logic tx_pend, tx_load;
  logic [7:0] tx_byte;
  logic len_hi_we, len_lo_we, cnt_clr, cnt_step, accept, rx_state;
  logic [LEN_W-1:0] len_q, cnt_q;

  bl_tx_slot u_slot (
    .clk(clk), .rst(rst), .load(tx_load), .load_byte(tx_byte),
    .tx_busy(tx_busy), .pend(tx_pend), .tx_valid(tx_valid), .tx_data(tx_data)
  );

  bl_len_counter #(.LEN_W(LEN_W)) u_len (
    .clk(clk), .rst(rst), .hi_we(len_hi_we), .lo_we(len_lo_we),
    .byte_in(rx_data), .clr(cnt_clr), .step(cnt_step),
    .len_q(len_q), .cnt_q(cnt_q)
  );

  assign rx_state = (state == S_WAIT_KEY) || (state == S_LEN_HI) ||
                    (state == S_LEN_LO) || (state == S_DATA);
  assign rx_ready = rx_state && !tx_pend;
  assign accept   = rx_valid && rx_ready;

  always_comb begin
    state_d   = state;
    tx_load   = 1'b0;
    tx_byte   = 8'h00;
    len_hi_we = 1'b0;
    len_lo_we = 1'b0;
    cnt_clr   = 1'b0;
    cnt_step  = 1'b0;
    case (state)
      S_IDLE: if (start) begin
        tx_load = 1'b1; tx_byte = BYTE_SYNC; state_d = S_WAIT_KEY;
      end
      S_WAIT_KEY: if (accept && rx_data == BYTE_KEY) begin
        tx_load = 1'b1; tx_byte = BYTE_ACK; state_d = S_LEN_HI;
      end
      S_LEN_HI: if (accept) begin
        tx_load = 1'b1; tx_byte = rx_data; len_hi_we = 1'b1; state_d = S_LEN_LO;
      end
      S_LEN_LO: if (accept) begin
        tx_load = 1'b1; tx_byte = rx_data; len_lo_we = 1'b1; cnt_clr = 1'b1;
        state_d = ({len_q[LEN_W-1:8], rx_data} == '0) ? S_CHECK : S_DATA;
      end
      S_DATA: if (accept) begin
        tx_load = 1'b1; tx_byte = rx_data; cnt_step = 1'b1;
        if (cnt_q + LEN_W'(1) == len_q) state_d = S_CHECK;
      end
      S_CHECK: if (!tx_pend) begin
        if (mem_has_data) state_d = S_ERASE;
        else begin
          tx_load = 1'b1; tx_byte = BYTE_ACK; state_d = S_DRAIN;
        end
      end
      S_ERASE: begin
        if (erase_fail) begin
          tx_load = 1'b1; tx_byte = BYTE_ERR; state_d = S_HALT;
        end else if (erase_done) begin
          tx_load = 1'b1; tx_byte = BYTE_ACK; state_d = S_DRAIN;
        end
      end
      S_DRAIN: if (!tx_pend) state_d = S_RUN;
      default: state_d = state;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      ram_we    <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= 8'h00;
      erase_req <= 1'b0;
      run       <= 1'b0;
      halted    <= 1'b0;
    end else begin
      state     <= state_d;
      ram_we    <= (state == S_DATA) && accept;
      if ((state == S_DATA) && accept) begin
        ram_addr  <= cnt_q[ADDR_W-1:0];
        ram_wdata <= rx_data;
      end
      erase_req <= (state_d == S_ERASE);
      run       <= (state_d == S_RUN);
      halted    <= (state_d == S_HALT);
    end
  end

  // R6: an echo must be queued before the next byte is taken
  a_r6_write_spacing: assert property (@(posedge clk) disable iff (rst)
    ram_we |=> !ram_we);
  // R9: request held until the engine answers
  a_r9_req_hold: assert property (@(posedge clk) disable iff (rst)
    (erase_req && !erase_done && !erase_fail) |=> erase_req);
  // R11: outcome levels are sticky and exclusive
  a_r11_run_sticky: assert property (@(posedge clk) disable iff (rst)
    run |=> run);
  a_r11_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);
  a_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(run && halted));
  // R10: a halted block takes no input and writes nothing
  a_r10_quiet: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!rx_ready && !ram_we && !erase_req));
endmodule

// File: tb/boot_handshake_bench.sv
module boot_handshake_bench;
  localparam int ADDR_W = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, rx_valid = 1'b0, tx_busy = 1'b0;
  logic mem_has_data = 1'b0, erase_done = 1'b0, erase_fail = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic rx_ready, tx_valid, ram_we, erase_req, run, halted;
  logic [7:0] tx_data, ram_wdata;
  logic [ADDR_W-1:0] ram_addr;

  always #5 clk = ~clk;

  boot_handshake #(.ADDR_W(ADDR_W)) u_boot_handshake (
    .clk(clk), .rst(rst), .start(start), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .tx_busy(tx_busy), .tx_valid(tx_valid), .tx_data(tx_data),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .mem_has_data(mem_has_data), .erase_req(erase_req), .erase_done(erase_done),
    .erase_fail(erase_fail), .run(run), .halted(halted)
  );

  int checks = 0, errors = 0;
  logic [7:0] txq [0:255];
  logic [7:0] ram_model [0:(1<<ADDR_W)-1];
  logic [7:0] sent [0:255];
  int txn = 0, rd = 0, wcount = 0, busy_cnt = 0, r6_bad = 0;
  bit erase_seen = 0;

  // transmitter model and port monitor, all at the falling edge
  initial forever begin
    @(negedge clk);
    if (tx_valid) begin
      if (tx_busy) r6_bad++;
      txq[txn[7:0]] = tx_data;
      txn++;
    end
    if (ram_we) begin
      ram_model[ram_addr] = ram_wdata;
      wcount++;
    end
    if (erase_req) erase_seen = 1;
    if (busy_cnt > 0) begin
      busy_cnt--;
      if (busy_cnt == 0) tx_busy = 1'b0;
    end else if (tx_valid) begin
      busy_cnt = 1 + int'($urandom % 4);
      tx_busy = 1'b1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic expect_tx(input logic [7:0] e, input string tag);
    int t = 0;
    while (txn <= rd && t < 2000) begin @(negedge clk); #1; t++; end
    if (txn <= rd) check(0, tag, -1, e);
    else begin
      check(txq[rd[7:0]] === e, tag, txq[rd[7:0]], e);
      rd++;
    end
  endtask

  task automatic send(input logic [7:0] b);
    int t = 0;
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    while (!rx_ready && t < 2000) begin @(negedge clk); t++; end
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  function automatic logic [7:0] junk_byte();
    logic [7:0] v = 8'($urandom);
    if (v == 8'h55) v = 8'h54;
    return v;
  endfunction

  task automatic session(input int n, input bit has, input bit fail, input int junk);
    int t;
    @(negedge clk);
    rst = 1'b1; mem_has_data = has;
    repeat (3) @(negedge clk);
    #1;
    check(!tx_valid && !ram_we && !erase_req && !run && !halted && !rx_ready,
          "R1 reset outputs", {tx_valid, ram_we, erase_req, run, halted, rx_ready}, 0);
    txn = 0; rd = 0; wcount = 0; erase_seen = 0;
    rst = 1'b0;
    @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    expect_tx(8'h00, "R2 sync byte");
    for (int j = 0; j < junk; j++) send(junk_byte());
    repeat (6) @(negedge clk);
    #1;
    check(txn == rd, "R3 junk ignored", txn - rd, 0);
    send(8'h55);
    expect_tx(8'hAA, "R3 key ack");
    send(8'(n >> 8)); expect_tx(8'(n >> 8), "R4 length high echo");
    send(8'(n));      expect_tx(8'(n), "R4 length low echo");
    for (int i = 0; i < n; i++) begin
      sent[i] = 8'($urandom);
      send(sent[i]);
      expect_tx(sent[i], "R5 data echo");
    end
    if (has) begin
      t = 0;
      while (!erase_req && t < 500) begin @(negedge clk); t++; end
      check(erase_req, "R9 erase requested", erase_req, 1);
      repeat (2 + ($urandom % 5)) @(negedge clk);
      check(erase_req, "R9 request held", erase_req, 1);
      if (fail) erase_fail = 1'b1; else erase_done = 1'b1;
      @(negedge clk);
      erase_fail = 1'b0; erase_done = 1'b0;
    end
    if (fail) begin
      expect_tx(8'hFF, "R10 error byte");
      repeat (5) @(negedge clk);
      check(halted && !run, "R10 halted", {halted, run}, 2'b10);
      rx_valid = 1'b1; rx_data = 8'h55;
      t = 0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (rx_ready) t++;
      end
      rx_valid = 1'b0;
      repeat (6) @(negedge clk);
      #1;
      check(t == 0 && txn == rd && wcount == n, "R10 input ignored after halt", txn - rd, 0);
      check(halted && !run, "R11 halt sticky", {halted, run}, 2'b10);
    end else begin
      expect_tx(8'hAA, has ? "R9 ack after erase" : "R8 ack without erase");
      if (!has) check(!erase_seen, "R8 no erase request", erase_seen, 0);
      repeat (5) @(negedge clk);
      check(run && !halted, has ? "R9 run" : "R8 run", {run, halted}, 2'b10);
      check(wcount == n, n == 0 ? "R7 no writes for zero length" : "R5 write count", wcount, n);
      for (int i = 0; i < n; i++)
        check(ram_model[i] === sent[i], "R5 ram content", ram_model[i], sent[i]);
      repeat (10) @(negedge clk);
      check(run && !halted, "R11 run sticky", {run, halted}, 2'b10);
    end
    check(r6_bad == 0, "R6 request only when not busy", r6_bad, 0);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_b007));
    session(5, 1'b0, 1'b0, 2);
    session(0, 1'b1, 1'b0, 0);
    session(20 + int'($urandom % 20), 1'b1, 1'b0, 3);
    session(0, 1'b0, 1'b0, 1);
    session(3, 1'b1, 1'b1, 1);
    session(1, 1'b0, 1'b0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule